// File: doc/BRIEF.md
# 64-bit Ternary Logic Unit

The unit applies any three-input boolean function, bit by bit, to three 64-bit operands. An 8-bit truth table chooses the function. One of the three operands is the old value of the destination, so the operation reads the destination, combines it with two sources and writes a new value back. Every 2^(2^3) = 256 three-input function can be built this way, including plain copies, majority, select-by-mask and parity.

A caller presents the operands, the truth table and a record flag with a one-cycle valid strobe. One cycle later the unit returns the registered result with a done strobe. When the record flag is set, the unit also returns a 4-bit condition field that describes the result as a signed 64-bit number, and raises a write flag for it. When the record flag is clear, the stored condition field keeps its value and the write flag stays low.

Top module: `ternlog_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are zero until the first valid operation: result 0, condition 0, done 0, condition write 0.
- R2: Result bit n equals truth-table bit k, where k = 4*dst[n] + 2*srca[n] + srcb[n]. The old destination is index bit 2, the first source is index bit 1 and the second source is index bit 0.
- R3: done is high in exactly the cycle after a cycle with valid high, and low otherwise. The new result is on the output in that same cycle.
- R4: A truth table of 0xFF gives all ones and a truth table of 0x00 gives all zeros, whatever the operands.
- R5: Without valid, the result output keeps its last value.
- R6: With the record flag set, the condition field in the done cycle has these bits: bit 3 set for a negative result (bit 63 set), bit 2 set for a positive non-zero result, bit 1 set for a zero result, bit 0 always 0. The condition write flag is high in that cycle.
- R7: With the record flag clear, or without valid, the condition field keeps its value and the condition write flag is low in the following cycle.
- R8: The destination operand really takes part: a truth table of 0xF0 returns dst, 0xCC returns srca and 0xAA returns srcb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| in_dst | input | 64 | Old destination value (index bit 2) |
| in_srca | input | 64 | First source (index bit 1) |
| in_srcb | input | 64 | Second source (index bit 0) |
| in_tt | input | 8 | Truth table |
| in_rec | input | 1 | Record flag: produce a condition field |
| out_done | output | 1 | Result valid, one cycle after in_valid |
| out_res | output | 64 | Registered result |
| out_cond | output | 4 | Condition field {neg, pos, zero, 0} |
| out_cond_wr | output | 1 | Condition field was written in this done cycle |

## Verification
Each result, the done strobe, the condition field and its write flag are due in the cycle after the edge that captures valid. The bench drives inputs on the falling edge. It samples all four outputs at the next falling edge, after the one capturing rising edge, and compares them with values computed in the bench. It then idles for one cycle and checks that done and the write flag have fallen and that the result and condition are unchanged. A running model of the condition field holds its value across operations without recording, so the check can verify that the field was left alone.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned N_IN    = 3;
  localparam int unsigned TT_W    = 1 << N_IN;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned CB_NEG  = 3;
  localparam int unsigned CB_POS  = 2;
  localparam int unsigned CB_ZERO = 1;
  localparam int unsigned CB_RSV  = 0;

  typedef logic [COND_W-1:0] cond_t;
endpackage

// File: rtl/tlu_rst_sync.sv
module tlu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tlu_lut_array.sv
module tlu_lut_array
  import tlu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]    dst,
  input  logic [W-1:0]    srca,
  input  logic [W-1:0]    srcb,
  input  logic [TT_W-1:0] tt,
  output logic [W-1:0]    y
);
  // One 8:1 selector per bit; the operand bits form the select.
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [N_IN-1:0] sel;
    assign sel  = {dst[g], srca[g], srcb[g]};
    assign y[g] = tt[sel];
  end
endmodule

// File: rtl/tlu_cond_gen.sv
module tlu_cond_gen
  import tlu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] res,
  output cond_t        flags
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero        = (res == '0);
    is_neg         = res[W-1];
    flags          = '0;
    flags[CB_NEG]  = is_neg;
    flags[CB_POS]  = !is_neg && !is_zero;
    flags[CB_ZERO] = is_zero;
    flags[CB_RSV]  = 1'b0;
  end
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import tlu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_srca,
  input  logic [W-1:0] in_srcb,
  input  logic [7:0]   in_tt,
  input  logic         in_rec,
  output logic         out_done,
  output logic [W-1:0] out_res,
  output logic [3:0]   out_cond,
  output logic         out_cond_wr
);
  logic         rst_n_i;
  logic [W-1:0] lut_y;
  cond_t        lut_flags;

  logic [W-1:0] res_q, res_d;
  cond_t        cond_q, cond_d;
  logic         done_q, done_d;
  logic         cwr_q, cwr_d;
  logic         res_en, cond_en;

  tlu_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  tlu_lut_array #(.W(W)) u_lut (
    .dst  (in_dst),
    .srca (in_srca),
    .srcb (in_srcb),
    .tt   (in_tt),
    .y    (lut_y)
  );

  tlu_cond_gen #(.W(W)) u_cond (
    .res   (lut_y),
    .flags (lut_flags)
  );

  // next-state
  always_comb begin
    res_en  = in_valid;
    cond_en = in_valid && in_rec;
    res_d   = res_en  ? lut_y     : res_q;
    cond_d  = cond_en ? lut_flags : cond_q;
    done_d  = in_valid;
    cwr_d   = cond_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_q  <= '0;
      cond_q <= '0;
      done_q <= 1'b0;
      cwr_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      cond_q <= cond_d;
      done_q <= done_d;
      cwr_q  <= cwr_d;
    end
  end

  assign out_res     = res_q;
  assign out_cond    = cond_q;
  assign out_done    = done_q;
  assign out_cond_wr = cwr_q;

  p_done_after_valid_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid |=> out_done);
  p_no_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> !out_done);
  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> $stable(out_res));
  p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && in_tt == 8'hFF) |=> (&out_res));
  p_all_zero_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && in_tt == 8'h00) |=> (out_res == '0));
  p_cond_shape_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_cond_wr |-> ($onehot(out_cond[3:1]) && !out_cond[0] && out_done));
  p_cond_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(in_valid && in_rec) |=> ($stable(out_cond) && !out_cond_wr));
  p_copy_dst_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && in_tt == 8'hF0) |=> (out_res == $past(in_dst)));
endmodule

// File: tb/tb_ternlog_unit.sv
module tb_ternlog_unit;
  localparam int W = 64;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_dst, in_srca, in_srcb;
  logic [7:0]   in_tt;
  logic         in_rec;
  logic         out_done;
  logic [W-1:0] out_res;
  logic [3:0]   out_cond;
  logic         out_cond_wr;

  int n_chk;
  int n_bad;
  logic [3:0]   mdl_cond;
  logic [W-1:0] mdl_res;

  ternlog_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
    .in_tt(in_tt), .in_rec(in_rec),
    .out_done(out_done), .out_res(out_res),
    .out_cond(out_cond), .out_cond_wr(out_cond_wr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W-1:0] f_res(logic [7:0] tt, logic [W-1:0] d,
                                         logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      int k;
      k = 4 * int'(d[i]) + 2 * int'(a[i]) + int'(b[i]);
      r[i] = tt[k];
    end
    return r;
  endfunction

  function automatic logic [3:0] f_cond(logic [W-1:0] r);
    if (r == '0)   return 4'b0010;
    if (r[W-1])    return 4'b1000;
    return 4'b0100;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [W-1:0] d, logic [W-1:0] a, logic [W-1:0] b,
                       logic [7:0] tt, logic rec, string req);
    logic [W-1:0] er;
    @(negedge clk);
    in_valid = 1'b1; in_dst = d; in_srca = a; in_srcb = b;
    in_tt = tt; in_rec = rec;
    er = f_res(tt, d, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    in_dst = ~d; in_srca = ~a; in_srcb = ~b; in_tt = ~tt; in_rec = ~rec;
    mdl_res = er;
    if (rec) mdl_cond = f_cond(er);
    chk({req, " R2 result"}, out_res, er);
    chk("R3 done", W'(out_done), W'(1));
    chk(rec ? "R6 cond" : "R7 cond held", W'(out_cond), W'(mdl_cond));
    chk(rec ? "R6 cond_wr" : "R7 cond_wr", W'(out_cond_wr), W'(rec));
    @(negedge clk);
    chk("R3 done low", W'(out_done), W'(0));
    chk("R5 result hold", out_res, mdl_res);
    chk("R7 idle cond", W'(out_cond), W'(mdl_cond));
    chk("R7 idle cond_wr", W'(out_cond_wr), W'(0));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ra, rb, rd;
    void'($urandom(32'd7));
    n_chk = 0; n_bad = 0;
    mdl_cond = '0; mdl_res = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_dst = '0; in_srca = '0;
    in_srcb = '0; in_tt = '0; in_rec = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 res in reset", out_res, '0);
    chk("R1 done in reset", W'(out_done), W'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 res", out_res, '0);
    chk("R1 cond", W'(out_cond), W'(0));
    chk("R1 done", W'(out_done), W'(0));
    chk("R1 cond_wr", W'(out_cond_wr), W'(0));

    // directed
    do_op(64'h8000_0000_FFFF_0000, 64'h8000_0000_FF00_FF00,
          64'h8000_0000_F0F0_F0F0, 8'h80, 1'b0, "R2 and3");
    do_op(64'h8000_0000_FFFF_0000, 64'h8000_0000_FF00_FF00,
          64'h8000_0000_F0F0_F0F0, 8'h80, 1'b1, "R6 and3 neg");
    do_op('0, '0, '0, 8'hFF, 1'b1, "R4 ones");
    do_op(64'h1234, 64'hFFFF, 64'h5A5A, 8'h00, 1'b1, "R4 zeros");
    do_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
          64'h0F0F_0F0F_F0F0_F0F0, 8'hF0, 1'b1, "R8 dst pos");
    do_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
          64'h0F0F_0F0F_F0F0_F0F0, 8'hCC, 1'b0, "R8 srca");
    do_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
          64'h0F0F_0F0F_F0F0_F0F0, 8'hAA, 1'b0, "R8 srcb");
    do_op(64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00,
          64'hF0F0_F0F0_F0F0_F0F0, 8'h96, 1'b1, "R2 parity");
    do_op(64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 8'h01, 1'b0, "R7 rec off");

    // random
    for (int i = 0; i < 400; i++) begin
      rd = {$urandom, $urandom};
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      do_op(rd, ra, rb, 8'($urandom), 1'($urandom), "R2 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule